// File: doc/BRIEF.md
# Two-Class Priority Interrupt Arbiter

This block picks one winning interrupt line out of a set of lines grouped in banks of 32. Each line brings four pieces of state: a pending bit, a mask bit, a class bit that places it in the normal class or the fast class, and a 6-bit priority. The arbiter examines only the lines that belong to the class chosen on its class input. Among those lines it finds the one with the most urgent priority.

The selection logic is combinational. The result reaches the outputs only when the evaluate strobe is high, and it is held between strobes. This lets a surrounding controller take a snapshot of the winner at a moment it chooses. For example, it can take the snapshot when it acknowledges the previous interrupt, and then read a stable line number while the inputs keep changing. The number of banks is a parameter from 1 to 3. The line vectors are sized from that parameter.

Top module: `prio_irq_arbiter`

## Requirements
- R1: A line is a candidate only when its pending bit is 1, its mask bit is 0, and its class bit equals `class_sel`.
- R2: Among candidates, the line with the numerically smallest priority wins. All 64 priority values 0..63 are ordered, and 0 is the most urgent.
- R3: When more than one candidate holds the best priority, the candidate with the largest line number wins.
- R4: Line `n` occupies bit `n` of each flat vector and bits `n*6 +: 6` of `prio_i`. The reported number is bank*32 + bit, so bank 1 bit 1 reports 33.
- R5: When no line is a candidate, a strobe captures winner 0 with `win_vld_o` low.
- R6: The outputs change only on a clock edge where `eval` is 1. At all other edges they keep their value, whatever the inputs do.
- R7: A strobe sets `win_vld_o` to 1 exactly when at least one candidate exists.
- R8: `class_sel` = 1 arbitrates the lines whose class bit is 1 (fast). `class_sel` = 0 arbitrates the lines whose class bit is 0 (normal).
- R9: While `rst_n` is low, and after it, until the first strobe, `win_o` is 0 and `win_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| class_sel | input | 1 | Class being arbitrated: 1 fast, 0 normal |
| eval | input | 1 | Capture strobe for the winner |
| pend_i | input | NUM_BANKS*32 | Pending bit per line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| fast_i | input | NUM_BANKS*32 | Class bit per line, 1 means fast |
| prio_i | input | NUM_BANKS*32*6 | Priority per line, 0 most urgent |
| win_o | output | clog2(NUM_BANKS*32) | Captured winning line number |
| win_vld_o | output | 1 | Captured flag: a candidate existed |

## Verification
Four behaviours are checked by assertions on every cycle. The outputs hold between strobes. The valid flag follows the presence of candidates at each strobe. The idle winner reads 0. A captured winner was a real candidate of the chosen class at the strobe. The order among candidates cannot be shown by these assertions: smallest priority first, ties to the highest line number, and the numbering across banks. These rules are shown by the bench's directed scenarios and by its reference model, which is compared at every clock under varied traffic.

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  class_sel,
  input  logic                                  eval,
  input  logic [NUM_BANKS*32-1:0]               pend_i,
  input  logic [NUM_BANKS*32-1:0]               mask_i,
  input  logic [NUM_BANKS*32-1:0]               fast_i,
  input  logic [NUM_BANKS*32*PRIO_W-1:0]        prio_i,
  output logic [$clog2(NUM_BANKS*32)-1:0]       win_o,
  output logic                                  win_vld_o
);
  localparam int LINES = NUM_BANKS * 32;
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0]  cand;
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;
  logic              any_c;

  assign cand = pend_i & ~mask_i & (class_sel ? fast_i : ~fast_i);

  always_comb begin
    best_p = '1;
    best_i = '0;
    any_c  = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (cand[i] && (prio_i[i*PRIO_W +: PRIO_W] <= best_p)) begin
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        best_i = IDX_W'(i);
        any_c  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_o     <= '0;
      win_vld_o <= 1'b0;
    end else if (eval) begin
      win_o     <= best_i;
      win_vld_o <= any_c;
    end
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ($stable(win_o) && $stable(win_vld_o)));

  p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eval |=> (win_vld_o == $past(|cand)));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld_o |-> (win_o == '0));

  p_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && (|cand)) |=> ((($past(cand) >> win_o) & LINES'(1)) != '0));
endmodule

// File: tb/prio_irq_arbiter_bench.sv
module prio_irq_arbiter_bench;
  localparam int NB = 3;
  localparam int N  = NB * 32;
  localparam int PW = 6;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic class_sel = 1'b0;
  logic eval = 1'b0;
  logic [N-1:0] pend = '0, mask = '0, fast = '0;
  logic [PW-1:0] pr [N];
  logic [N*PW-1:0] prio_flat;
  logic [IW-1:0] win;
  logic vld;
  int checks = 0;
  int errors = 0;
  int exp_w = 0;
  int exp_v = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = pr[i];

  prio_irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) u_prio_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .class_sel(class_sel), .eval(eval),
    .pend_i(pend), .mask_i(mask), .fast_i(fast), .prio_i(prio_flat),
    .win_o(win), .win_vld_o(vld));

  function automatic void ref_pick(output int w, output int v);
    int best;
    w = 0; v = 0; best = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && !mask[i] && (fast[i] == class_sel)) begin
        if (!v || int'(pr[i]) < best) begin
          best = int'(pr[i]); w = i; v = 1;
        end
      end
    end
  endfunction

  always @(posedge clk) begin
    int w, v;
    if (!rst_n) begin
      exp_w <= 0; exp_v <= 0;
    end else if (eval) begin
      ref_pick(w, v);
      exp_w <= w; exp_v <= v;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(win) != exp_w || int'(vld) != exp_v) begin
        errors++;
        $display("FAIL R2/R3/R6 model: got win=%0d vld=%0d expected win=%0d vld=%0d",
                 win, vld, exp_w, exp_v);
      end
    end
  end

  task automatic chk(input string tag, input int ew, input int ev);
    checks++;
    if (int'(win) != ew || int'(vld) != ev) begin
      errors++;
      $display("FAIL %s: got win=%0d vld=%0d expected win=%0d vld=%0d", tag, win, vld, ew, ev);
    end
  endtask

  task automatic clear_all();
    pend = '0; mask = '0; fast = '0; class_sel = 1'b0;
    for (int i = 0; i < N; i++) pr[i] = '0;
  endtask

  task automatic strobe();
    eval = 1'b1;
    @(negedge clk);
    eval = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: got no end expected end of run");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    chk("R9 during reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 after reset", 0, 0);

    strobe();
    chk("R5 nothing pending", 0, 0);

    pend[5] = 1'b1; pr[5] = 6'd10;
    strobe();
    chk("R1 single normal line", 5, 1);
    chk("R7 valid with candidate", 5, 1);

    mask[5] = 1'b1;
    strobe();
    chk("R1 masked line excluded", 0, 0);
    mask[5] = 1'b0;

    fast[5] = 1'b1;
    strobe();
    chk("R8 fast line ignored in normal class", 0, 0);
    class_sel = 1'b1;
    strobe();
    chk("R8 fast line wins in fast class", 5, 1);

    clear_all();
    pend[70] = 1'b1; pr[70] = 6'd3;
    pend[10] = 1'b1; pr[10] = 6'd7;
    strobe();
    chk("R2 lower priority value wins", 70, 1);
    pr[10] = 6'd2;
    strobe();
    chk("R2 reordered priorities", 10, 1);
    pr[10] = 6'd63; pr[70] = 6'd62;
    strobe();
    chk("R2 top of 6-bit range", 70, 1);

    clear_all();
    pend[3] = 1'b1; pend[40] = 1'b1; pend[95] = 1'b1;
    pr[3] = 6'd4; pr[40] = 6'd4; pr[95] = 6'd4;
    strobe();
    chk("R3 tie goes to highest line", 95, 1);
    pr[95] = 6'd9;
    strobe();
    chk("R3 tie between 3 and 40", 40, 1);

    clear_all();
    pend[33] = 1'b1;
    strobe();
    chk("R4 bank 1 bit 1", 33, 1);
    pend[33] = 1'b0; pend[64] = 1'b1;
    strobe();
    chk("R4 bank 2 bit 0", 64, 1);

    pend[64] = 1'b0; pend[12] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 no strobe keeps winner", 64, 1);
    pend = '0;
    @(negedge clk);
    chk("R6 no strobe keeps valid", 64, 1);

    for (int k = 0; k < 400; k++) begin
      for (int b = 0; b < NB; b++) begin
        pend[b*32 +: 32] = $urandom() & $urandom();
        mask[b*32 +: 32] = $urandom() & $urandom();
        fast[b*32 +: 32] = $urandom();
      end
      for (int i = 0; i < N; i++)
        pr[i] = ($urandom_range(0, 9) == 0) ? 6'd63 : PW'($urandom_range(0, 5));
      class_sel = $urandom_range(0, 1) == 1;
      eval = $urandom_range(0, 2) == 0;
      @(negedge clk);
    end
    eval = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule